// File: doc/BRIEF.md
# Pre-empting Link Frame Composer

This block sits in the transmit side of a data-link layer and merges three frame sources into one outgoing symbol stream. The sources are a low-priority data queue (traffic class 0), a high-priority data queue (traffic class 1) and a control-frame queue. Each source presents one symbol per cycle with start-of-frame and end-of-frame flags. The composer pulls a symbol from exactly one source per cycle by raising that source's ready.

When pre-emption is enabled and a frame of higher rank shows its start symbol while a data frame is partway through, the composer stops the data frame at the next symbol boundary. It then sends the new frame complete and afterwards continues the interrupted frame with its next unsent symbol. Interruptions can nest, so a class 0 frame can hold a class 1 frame that in turn holds a control frame. The interrupted sources are remembered in a small last-in-first-out stack of source identifiers. The source queues hold their own place, because their ready stays low while they are suspended. When pre-emption is disabled, every frame runs to its end before any other frame starts.

The controller has three states:
- IDLE: no frame is open.
- DATA: a data frame is open and may be interrupted.
- CTRL: a control frame is open and cannot be interrupted.

Each granted cycle is classed as one of the following transitions:
- START: a frame opens from IDLE.
- HOLD: the open frame sends its next symbol.
- PREEMPT: the open frame is pushed and a higher-rank frame opens.

On an end-of-frame symbol the controller either does a RESUME, popping the stack and returning to DATA, or a FINISH, returning to IDLE.

Top module: `dlc_preempt_composer`

## Requirements
- R1: While reset is asserted and right after it, out_valid is 0, and no ready is raised while no source is valid.
- R2: From IDLE, when several sources show a start symbol together, rank decides: source 2 (control) first, then source 1 (class 1), then source 0 (class 0).
- R3: With preempt_en set, a class 1 start symbol that appears while a class 0 frame is open is granted on the next cycle, and the class 1 frame is sent whole.
- R4: With preempt_en set, a control start symbol interrupts an open class 0 or class 1 frame in the same way.
- R5: Interruption nests: a control frame can interrupt a class 1 frame that is itself interrupting a class 0 frame.
- R6: After an inserted frame ends, the most recently interrupted frame resumes with exactly the symbol after its last sent one. No symbol is lost or repeated.
- R7: A frame never interrupts one of equal or higher rank. A class 0 start symbol during a class 1 frame, or any start symbol during a control frame, waits until that frame has ended.
- R8: With preempt_en clear, an open frame always runs to its end before any start symbol is accepted. Waiting frames then follow in rank order.
- R9: A symbol accepted on a clock edge appears on the output at that edge. The output carries out_sof and out_eof copied from the input and out_cls equal to the source number (0, 1, 2). Out_valid is 0 in cycles with no accept.
- R10: At most one ready is high in any cycle, and a ready is only raised on a valid source.
- R11: A one-symbol frame (start and end flags both set) can be inserted, and the interrupted frame continues on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| preempt_en | input | 1 | 1 allows interruption of data frames |
| in_valid | input | 3 | Per-source symbol valid (bit 0 class 0, bit 1 class 1, bit 2 control) |
| in_sof | input | 3 | Per-source start-of-frame flag |
| in_eof | input | 3 | Per-source end-of-frame flag |
| in_sym | input | 3*SYM_W | Per-source symbol, source n at bits n*SYM_W upward |
| in_ready | output | 3 | Per-source accept, at most one high |
| out_valid | output | 1 | Output symbol valid |
| out_sof | output | 1 | Output start-of-frame flag |
| out_eof | output | 1 | Output end-of-frame flag |
| out_cls | output | 2 | Source number of the output symbol |
| out_sym | output | SYM_W | Output symbol |

## Verification
The bench opens a low-rank frame and triggers a higher-rank frame after every possible number of already-sent symbols. It does this for class 1 over class 0, control over class 0 and control over class 1, and for every pair of offsets in the two-level nested case. This separates a composer that cuts at the right boundary and resumes at the right symbol from one that drops, repeats or reorders symbols. The same triggers are replayed with pre-emption off and with rank-reversed pairs: class 0 against class 1, and class 1 against an open control frame. These runs must produce whole frames back to back. Simultaneous starts from IDLE and one-symbol inserted frames cover arbitration and the case where a push and an end fall in the same cycle.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    localparam int NSRC = 3;
    localparam int SRCW = 2;

    typedef enum logic [1:0] {
        SRC_TC0 = 2'd0,
        SRC_TC1 = 2'd1,
        SRC_CTL = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_CTRL = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        TR_NONE    = 2'd0,
        TR_START   = 2'd1,
        TR_HOLD    = 2'd2,
        TR_PREEMPT = 2'd3
    } trans_e;
endpackage

// File: rtl/dlc_prio_pick.sv
module dlc_prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0]         req,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    // highest index wins: later iterations override earlier ones
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dlc_susp_stack.sv
module dlc_susp_stack #(
    parameter int DEPTH = 3,
    parameter int EW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [EW-1:0] push_val,
    output logic [EW-1:0] top,
    output logic          full,
    output logic          empty
);
    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0] level_q;
    logic [EW-1:0] mem_q [DEPTH];

    assign full  = (level_q == LW'(DEPTH));
    assign empty = (level_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (push && !full) begin
            level_q <= level_q + 1'b1;
        end else if (pop && !empty) begin
            level_q <= level_q - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (push && level_q == LW'(g)) begin
                mem_q[g] <= push_val;
            end
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level_q == LW'(i + 1)) top = mem_q[i];
        end
    end
endmodule

// File: rtl/dlc_out_stage.sv
module dlc_out_stage #(
    parameter int SYM_W = 8,
    parameter int CW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [SYM_W-1:0] sym,
    input  logic             sof,
    input  logic             eof,
    input  logic [CW-1:0]    cls,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_sym,
    output logic             out_sof,
    output logic             out_eof,
    output logic [CW-1:0]    out_cls
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sym   <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_cls   <= '0;
        end else begin
            out_valid <= take;
            if (take) begin
                out_sym <= sym;
                out_sof <= sof;
                out_eof <= eof;
                out_cls <= cls;
            end
        end
    end
endmodule

// File: rtl/dlc_preempt_composer.sv
module dlc_preempt_composer
    import dlc_pkg::*;
#(
    parameter int SYM_W       = 8,
    parameter int STACK_DEPTH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  preempt_en,
    input  logic [NSRC-1:0]       in_valid,
    input  logic [NSRC-1:0]       in_sof,
    input  logic [NSRC-1:0]       in_eof,
    input  logic [NSRC*SYM_W-1:0] in_sym,
    output logic [NSRC-1:0]       in_ready,
    output logic                  out_valid,
    output logic                  out_sof,
    output logic                  out_eof,
    output logic [SRCW-1:0]       out_cls,
    output logic [SYM_W-1:0]      out_sym
);
    state_e state_q, state_d;
    src_e   cur_q, cur_d;
    trans_e tr;

    logic [NSRC-1:0]  start_req;
    logic             pick_found;
    logic [SRCW-1:0]  pick_idx;
    logic             gnt_vld;
    logic [SRCW-1:0]  gnt_idx;
    logic             push, pop;
    logic [SRCW-1:0]  stk_top;
    logic             stk_full, stk_empty;
    logic [SYM_W-1:0] sel_sym;
    logic             sel_eof, sel_sof;

    assign start_req = in_valid & in_sof;

    dlc_prio_pick #(.N(NSRC)) u_pick (
        .req   (start_req),
        .found (pick_found),
        .idx   (pick_idx)
    );

    dlc_susp_stack #(.DEPTH(STACK_DEPTH), .EW(SRCW)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_val (cur_q),
        .top      (stk_top),
        .full     (stk_full),
        .empty    (stk_empty)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= SRC_TC0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    // grant decision (output process)
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = cur_q;
        tr      = TR_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_found) begin
                    gnt_vld = 1'b1;
                    gnt_idx = pick_idx;
                    tr      = TR_START;
                end
            end
            ST_DATA: begin
                if (preempt_en && pick_found && (pick_idx > cur_q) && !stk_full) begin
                    gnt_vld = 1'b1;
                    gnt_idx = pick_idx;
                    tr      = TR_PREEMPT;
                end else if (in_valid[cur_q]) begin
                    gnt_vld = 1'b1;
                    tr      = TR_HOLD;
                end
            end
            ST_CTRL: begin
                if (in_valid[cur_q]) begin
                    gnt_vld = 1'b1;
                    tr      = TR_HOLD;
                end
            end
            default: begin
                gnt_vld = 1'b0;
            end
        endcase
    end

    always_comb begin
        in_ready = '0;
        sel_sym  = '0;
        sel_sof  = 1'b0;
        sel_eof  = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (gnt_idx == SRCW'(i)) begin
                in_ready[i] = gnt_vld;
                sel_sym     = in_sym[i*SYM_W +: SYM_W];
                sel_sof     = in_sof[i];
                sel_eof     = in_eof[i];
            end
        end
    end

    // next state: START / HOLD / PREEMPT, and on end RESUME or FINISH
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        push    = 1'b0;
        pop     = 1'b0;
        if (gnt_vld) begin
            if (sel_eof) begin
                if (tr == TR_PREEMPT) begin
                    // one-symbol insertion: the open frame stays current
                    state_d = state_q;
                end else if (!stk_empty) begin
                    pop     = 1'b1;
                    cur_d   = src_e'(stk_top);
                    state_d = ST_DATA;
                end else begin
                    state_d = ST_IDLE;
                end
            end else begin
                push    = (tr == TR_PREEMPT);
                cur_d   = src_e'(gnt_idx);
                state_d = (gnt_idx == SRC_CTL) ? ST_CTRL : ST_DATA;
            end
        end
    end

    dlc_out_stage #(.SYM_W(SYM_W), .CW(SRCW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (gnt_vld),
        .sym       (sel_sym),
        .sof       (sel_sof),
        .eof       (sel_eof),
        .cls       (gnt_idx),
        .out_valid (out_valid),
        .out_sym   (out_sym),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .out_cls   (out_cls)
    );
endmodule

// File: rtl/dlc_preempt_sva.sv
module dlc_preempt_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       preempt_en,
    input logic [2:0] in_valid,
    input logic [2:0] in_sof,
    input logic [2:0] in_eof,
    input logic [2:0] in_ready,
    input logic       out_valid
);
    logic [2:0] acc;
    logic [2:0] open_q;

    assign acc = in_ready & in_valid;

    // frames open per source, seen only from the port handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
        end else begin
            for (int s = 0; s < 3; s++) begin
                if (acc[s]) begin
                    if (in_eof[s])      open_q[s] <= 1'b0;
                    else if (in_sof[s]) open_q[s] <= 1'b1;
                end
            end
        end
    end

    assert_ready_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));

    assert_ready_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready & ~in_valid) == 3'b000);

    assert_out_follows_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|acc) |=> out_valid);

    assert_no_spurious_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|acc) |=> !out_valid);

    assert_ctrl_not_preempted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        open_q[2] |-> (in_ready[1:0] == 2'b00));

    assert_tc0_below_tc1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        open_q[1] |-> !in_ready[0]);

    assert_no_start_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!preempt_en && (|open_q)) |-> ((acc & in_sof) == 3'b000));
endmodule

bind dlc_preempt_composer dlc_preempt_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .preempt_en (preempt_en),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .in_ready   (in_ready),
    .out_valid  (out_valid)
);

// File: tb/tb_dlc_preempt_composer.sv
module tb_dlc_preempt_composer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        preempt_en = 1'b0;
    logic [2:0]  in_valid, in_sof, in_eof, in_ready;
    logic [23:0] in_sym;
    logic        out_valid, out_sof, out_eof;
    logic [1:0]  out_cls;
    logic [7:0]  out_sym;

    always #4 clk = ~clk;

    dlc_preempt_composer dut (
        .clk(clk), .rst_n(rst_n), .preempt_en(preempt_en),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_sym(in_sym),
        .in_ready(in_ready), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .out_cls(out_cls), .out_sym(out_sym)
    );

    int   len [3];
    int   trs [3];
    int   trc [3];
    logic act [3];
    int   cnt [3];
    logic clr = 1'b1;
    int   n_chk = 0;
    int   n_fail = 0;
    int   r10_bad = 0;
    int   got [$];
    int   exp_q [$];

    // source models: symbol = source*16 + position
    always_comb begin
        for (int s = 0; s < 3; s++) begin
            in_valid[s] = act[s] && (cnt[s] < len[s]) &&
                          (trs[s] == 3 || cnt[trs[s] % 3] >= trc[s]);
            in_sof[s]   = (cnt[s] == 0);
            in_eof[s]   = (cnt[s] == len[s] - 1);
            in_sym[s*8 +: 8] = 8'(s * 16 + cnt[s]);
        end
    end

    always @(posedge clk) begin
        for (int s = 0; s < 3; s++) begin
            if (clr) cnt[s] <= 0;
            else if (in_ready[s] && in_valid[s]) cnt[s] <= cnt[s] + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && out_valid)
            got.push_back({20'd0, out_sof, out_eof, out_cls, out_sym});
        if (rst_n && (($countones(in_ready) > 1) || ((in_ready & ~in_valid) != 0)))
            r10_bad++;
    end

    task automatic chk(input string tag, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    function automatic void seg(input int s, input int a, input int b);
        for (int p = a; p < b; p++)
            exp_q.push_back(((p == 0) ? 32'h800 : 0) | ((p == len[s] - 1) ? 32'h400 : 0) |
                            (s << 8) | (s * 16 + p));
    endfunction

    task automatic cfg(input int s, input logic a, input int l, input int ts, input int tc);
        act[s] = 1'b0;
        len[s] = l;
        trs[s] = ts;
        trc[s] = tc;
        if (a) act[s] = 1'b0;
    endtask

    task automatic run_case(input string tag, input logic en, input logic a0,
                            input logic a1, input logic a2);
        int w;
        for (int s = 0; s < 3; s++) act[s] = 1'b0;
        repeat (2) @(negedge clk);
        got.delete();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        preempt_en = en;
        act[0] = a0; act[1] = a1; act[2] = a2;
        w = 0;
        while (got.size() < exp_q.size() && w < 300) begin
            @(negedge clk);
            w++;
        end
        repeat (4) @(negedge clk);
        chk({tag, " count"}, got.size(), exp_q.size());
        for (int i = 0; i < exp_q.size(); i++)
            chk(tag, (i < got.size()) ? got[i] : -1, exp_q[i]);
        for (int s = 0; s < 3; s++) act[s] = 1'b0;
        exp_q.delete();
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int s = 0; s < 3; s++) begin
            act[s] = 1'b0; len[s] = 1; trs[s] = 3; trc[s] = 0;
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R1 out_valid after reset", out_valid, 0);
        chk("R1 ready idle", in_ready, 0);

        // R9: one-edge output timing and tagging, single control symbol
        cfg(2, 1, 1, 3, 0);
        act[2] = 1'b1;
        #1;
        chk("R9 ready same cycle", in_ready, 3'b100);
        chk("R9 no output before edge", out_valid, 0);
        @(negedge clk);
        act[2] = 1'b0;
        chk("R9 out_valid", out_valid, 1);
        chk("R9 out_sym", out_sym, 8'h20);
        chk("R9 out_cls", out_cls, 2);
        chk("R9 sof/eof", {out_sof, out_eof}, 2'b11);
        @(negedge clk);
        chk("R9 idle after", out_valid, 0);

        // R2: simultaneous starts from IDLE, both modes
        for (int e = 0; e < 2; e++) begin
            cfg(0, 1, 5, 3, 0); cfg(1, 1, 3, 3, 0); cfg(2, 1, 2, 3, 0);
            seg(2, 0, 2); seg(1, 0, 3); seg(0, 0, 5);
            run_case("R2 rank order", e[0], 1, 1, 1);
        end

        // R3/R6: class 1 interrupts class 0 after k symbols
        for (int k = 1; k < 5; k++) begin
            cfg(0, 1, 5, 3, 0); cfg(1, 1, 3, 0, k);
            seg(0, 0, k); seg(1, 0, 3); seg(0, k, 5);
            run_case("R3 R6 tc1 over tc0", 1, 1, 1, 0);
        end

        // R8: same trigger, pre-emption off
        for (int k = 1; k < 5; k++) begin
            cfg(0, 1, 5, 3, 0); cfg(1, 1, 3, 0, k);
            seg(0, 0, 5); seg(1, 0, 3);
            run_case("R8 off tc1 waits", 0, 1, 1, 0);
        end

        // R4: control interrupts class 0, then class 1
        for (int k = 1; k < 5; k++) begin
            cfg(0, 1, 5, 3, 0); cfg(2, 1, 2, 0, k);
            seg(0, 0, k); seg(2, 0, 2); seg(0, k, 5);
            run_case("R4 ctl over tc0", 1, 1, 0, 1);
        end
        for (int j = 1; j < 3; j++) begin
            cfg(1, 1, 3, 3, 0); cfg(2, 1, 2, 1, j);
            seg(1, 0, j); seg(2, 0, 2); seg(1, j, 3);
            run_case("R4 ctl over tc1", 1, 0, 1, 1);
        end

        // R5/R6: two-level nesting at every offset pair
        for (int k = 1; k < 5; k++) begin
            for (int j = 1; j < 3; j++) begin
                cfg(0, 1, 5, 3, 0); cfg(1, 1, 3, 0, k); cfg(2, 1, 2, 1, j);
                seg(0, 0, k); seg(1, 0, j); seg(2, 0, 2); seg(1, j, 3); seg(0, k, 5);
                run_case("R5 R6 nested", 1, 1, 1, 1);
            end
        end

        // R8: nested triggers with pre-emption off
        cfg(0, 1, 5, 3, 0); cfg(1, 1, 3, 0, 2); cfg(2, 1, 2, 1, 1);
        seg(0, 0, 5); seg(1, 0, 3); seg(2, 0, 2);
        run_case("R8 off nested", 0, 1, 1, 1);

        // R7: lower or equal rank never interrupts
        for (int j = 1; j < 3; j++) begin
            cfg(1, 1, 3, 3, 0); cfg(0, 1, 5, 1, j);
            seg(1, 0, 3); seg(0, 0, 5);
            run_case("R7 tc0 during tc1", 1, 1, 1, 0);
        end
        cfg(2, 1, 2, 3, 0); cfg(1, 1, 3, 2, 1);
        seg(2, 0, 2); seg(1, 0, 3);
        run_case("R7 tc1 during ctl", 1, 0, 1, 1);

        // R11: one-symbol inserted frames
        cfg(0, 1, 5, 3, 0); cfg(2, 1, 1, 0, 2);
        seg(0, 0, 2); seg(2, 0, 1); seg(0, 2, 5);
        run_case("R11 single ctl insert", 1, 1, 0, 1);
        cfg(0, 1, 5, 3, 0); cfg(1, 1, 1, 0, 3);
        seg(0, 0, 3); seg(1, 0, 1); seg(0, 3, 5);
        run_case("R11 single tc1 insert", 1, 1, 1, 0);

        chk("R10 ready one-hot and valid", r10_bad, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule